// File: doc/BRIEF.md
# 4:2:0 Chroma Upsampler with Line Cache

This block rebuilds full-resolution chrominance for a display pipeline from 4:2:0 subsampled Cb/Cr planes. A chroma plane of `W` samples by `H` lines becomes an output of `2W` by `2H` Cb/Cr pairs, one pair per output pixel, sent in raster order. Between two chroma lines the block keeps one line in a local cache. Even output lines are built from one chroma line. Odd output lines blend the cached line with the next one.

The block asks for each chroma line with a one-cycle request pulse. The source then sends the line over a valid/ready sample stream. The first chroma line of a frame arrives while the cache is still empty, so it is used straight from the stream and also written into the cache. On each odd output line that has a following chroma line, that line is fetched. Each new sample is written into the cache at the same address from which the current line's sample is being read. At the right edge the last chroma column is repeated. At the bottom the last chroma line is repeated. The output has no ready input. Whenever a needed sample has not yet arrived, the block stalls and raises no output valid.

Top module: `chroma_upsampler420`

## Requirements
- R1: After reset and while idle, `out_valid_o`, `in_ready_o` and `line_req_o` are low.
- R2: A frame issues exactly `H` one-cycle `line_req_o` pulses. One comes at the start of output line 0, and one at the start of every odd output line except the last. Each pulse comes only after all `W` samples of the previous request have been accepted.
- R3: On even output line `2j`, pixel `2i` equals chroma sample `C[j][i]`, separately for Cb and Cr.
- R4: On even output line `2j`, pixel `2i+1` equals `(C[j][i] + C[j][i+1] + 1) >> 1`.
- R5: On odd output line `2j+1`, pixel `2i` equals `(C[j][i] + C[j+1][i] + 1) >> 1`.
- R6: On odd output line `2j+1`, pixel `2i+1` equals `(C[j][i] + C[j][i+1] + C[j+1][i] + C[j+1][i+1] + 2) >> 2`.
- R7: Column `i+1 = W` does not exist, so column `W-1` stands in for it: the last output pixel of a line repeats the last chroma column.
- R8: Line `j+1 = H` does not exist, so line `H-1` stands in for it. The final output line therefore equals the horizontal interpolation of the last chroma line.
- R9: A frame outputs exactly `2W x 2H` pixels in raster order. `out_eol_o` marks the last pixel of every output line. `out_eof_o` marks only the final pixel of the frame.
- R10: A sample is accepted only when `in_valid_i` and `in_ready_o` are both high. Each request takes exactly `W` samples. While the source withholds data, no output is produced and none is lost.
- R11: The chroma width and height are taken from `cfg_cw_i`/`cfg_ch_i` when `start_i` is seen while idle. A `start_i` pulse or a configuration change during a frame has no effect on that frame's output.
- R12: Any `W` from 1 to `MAX_CW` (default 1024) and any `H` from 1 to `MAX_CH` is handled. Cb and Cr share one cache entry per column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a frame (taken while idle) |
| cfg_cw_i | input | CW_W | Chroma line width `W` (1..MAX_CW) |
| cfg_ch_i | input | CH_W | Chroma line count `H` (1..MAX_CH) |
| line_req_o | output | 1 | One-cycle request for the next chroma line |
| in_valid_i | input | 1 | Chroma sample valid |
| in_ready_o | output | 1 | Block accepts a chroma sample |
| in_cb_i | input | DATA_W | Incoming Cb sample |
| in_cr_i | input | DATA_W | Incoming Cr sample |
| out_valid_o | output | 1 | Output pixel valid |
| out_cb_o | output | DATA_W | Upsampled Cb |
| out_cr_o | output | DATA_W | Upsampled Cr |
| out_eol_o | output | 1 | Last pixel of an output line |
| out_eof_o | output | 1 | Last pixel of the frame |

## Verification
The bench covers these corner cases:
- A one-column plane, where every odd pixel is an edge repeat. A design that read past the line end would mix in stale cache data.
- A one-line plane, where only the bottom repeat applies. A design that fetched a second line would hang or pull in a foreign line.
- Full-scale samples of 255, which would wrap a sum that is too narrow to hold the rounding term.
- Heavy random gaps on the stream, so that a design that dropped or duplicated samples while stalled would shift every later expected pixel.
- A maximal 1024-wide line, which exercises the whole cache address range.
- A mid-frame start and configuration change, which would corrupt the frame if the block re-latched them.

// File: rtl/chroma_up_pkg.sv
package chroma_up_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_FIRST,
    ST_ODD,
    ST_EVEN
  } seq_state_e;

  // which kernel produces the pixel being emitted
  typedef enum logic [1:0] {
    K_EVEN_NEW,  // even column from the freshly obtained column
    K_EVEN_CUR,  // even column from the held column
    K_ODD_NEW,   // odd column: held column and fresh column
    K_ODD_DUP    // odd column at the right edge: held column repeated
  } kernel_kind_e;

endpackage

// File: rtl/chroma_line_cache.sv
module chroma_line_cache #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  parameter int NCH    = 2,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NCH-1:0][DATA_W-1:0]    wr_data,
  output logic [NCH-1:0][DATA_W-1:0]    rd_data
);

  // one entry holds every chroma channel of a column
  logic [NCH*DATA_W-1:0] mem [DEPTH];

  // read is combinational: a same-address write in this cycle is seen next cycle
  assign rd_data = mem[addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_data;
  end

endmodule

// File: rtl/chroma_line_seq.sv
module chroma_line_seq
  import chroma_up_pkg::*;
#(
  parameter int MAX_CW = 1024,
  parameter int MAX_CH = 1024,
  localparam int CW_W   = $clog2(MAX_CW + 1),
  localparam int CH_W   = $clog2(MAX_CH + 1),
  localparam int ADDR_W = $clog2(MAX_CW),
  localparam int OL_W   = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CW_W-1:0]   cfg_cw_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic              in_valid_i,
  output logic              line_req_o,
  output logic              in_ready_o,
  output logic              col_take_o,
  output logic              emit_o,
  output kernel_kind_e      emit_kind_o,
  output logic              top_from_stream_o,
  output logic              bot_from_stream_o,
  output logic [ADDR_W-1:0] cache_addr_o,
  output logic              cache_wr_o,
  output logic              eol_o,
  output logic              eof_o,
  output logic [CW_W-1:0]   active_cw_o
);

  seq_state_e        st;
  logic [CW_W-1:0]   cw_q;
  logic [CH_W-1:0]   ch_q;
  logic [OL_W-1:0]   oline;
  logic [ADDR_W-1:0] col;

  // named line / column events
  logic [CH_W-1:0] pair_idx;
  logic line_odd, first_line, has_next, need_stream;
  logic last_col, last_line, fetch_phase, col_avail;

  assign pair_idx    = oline[OL_W-1:1];
  assign line_odd    = oline[0];
  assign first_line  = (oline == '0);
  assign has_next    = ((pair_idx + CH_W'(1)) < ch_q);
  assign need_stream = first_line || (line_odd && has_next);
  assign last_col    = ((CW_W'(col) + CW_W'(1)) == cw_q);
  assign last_line   = (oline == ({ch_q, 1'b0} - OL_W'(1)));

  assign fetch_phase = (st == ST_FIRST) || (st == ST_ODD && !last_col);
  assign col_avail   = !need_stream || in_valid_i;

  assign line_req_o  = (st == ST_REQ) && need_stream;
  assign in_ready_o  = fetch_phase && need_stream;
  assign col_take_o  = fetch_phase && col_avail;
  assign cache_wr_o  = col_take_o && need_stream;
  assign cache_addr_o = (st == ST_FIRST) ? '0 : (col + ADDR_W'(1));

  assign top_from_stream_o = first_line;
  assign bot_from_stream_o = line_odd && has_next;

  assign eol_o = (st == ST_ODD) && last_col;
  assign eof_o = eol_o && last_line;
  assign active_cw_o = cw_q;

  always_comb begin
    emit_o      = 1'b0;
    emit_kind_o = K_EVEN_CUR;
    unique case (st)
      ST_FIRST: begin
        emit_o      = col_avail;
        emit_kind_o = K_EVEN_NEW;
      end
      ST_ODD: begin
        emit_o      = last_col || col_avail;
        emit_kind_o = last_col ? K_ODD_DUP : K_ODD_NEW;
      end
      ST_EVEN: begin
        emit_o      = 1'b1;
        emit_kind_o = K_EVEN_CUR;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cw_q  <= CW_W'(1);
      ch_q  <= CH_W'(1);
      oline <= '0;
      col   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start_i) begin
          cw_q  <= cfg_cw_i;
          ch_q  <= cfg_ch_i;
          oline <= '0;
          col   <= '0;
          st    <= ST_REQ;
        end
        ST_REQ: begin
          col <= '0;
          st  <= ST_FIRST;
        end
        ST_FIRST: if (col_avail) st <= ST_ODD;
        ST_ODD: begin
          if (last_col) begin
            if (last_line) st <= ST_IDLE;
            else begin
              oline <= oline + OL_W'(1);
              st    <= ST_REQ;
            end
          end else if (col_avail) begin
            col <= col + ADDR_W'(1);
            st  <= ST_EVEN;
          end
        end
        ST_EVEN: st <= ST_ODD;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!in_ready_o && !emit_o && !line_req_o)); // R1
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_req_o |=> !line_req_o); // R2
  AST_WR_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    cache_wr_o |-> (CW_W'(cache_addr_o) < cw_q)); // R12
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && $past(st) != ST_IDLE) |-> ($stable(cw_q) && $stable(ch_q))); // R11

endmodule

// File: rtl/chroma_kernel.sv
module chroma_kernel
  import chroma_up_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NCH    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       take_i,
  input  logic                       emit_i,
  input  kernel_kind_e               kind_i,
  input  logic                       eol_i,
  input  logic                       eof_i,
  input  logic [NCH-1:0][DATA_W-1:0] new_top_i,
  input  logic [NCH-1:0][DATA_W-1:0] new_bot_i,
  output logic                       out_valid_o,
  output logic [NCH-1:0][DATA_W-1:0] out_pix_o,
  output logic                       out_eol_o,
  output logic                       out_eof_o
);

  function automatic logic [DATA_W-1:0] mean2(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    logic [DATA_W:0] s;
    s = {1'b0, a} + {1'b0, b} + (DATA_W+1)'(1);
    return s[DATA_W:1];
  endfunction

  function automatic logic [DATA_W-1:0] mean4(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b,
                                              input logic [DATA_W-1:0] c,
                                              input logic [DATA_W-1:0] d);
    logic [DATA_W+1:0] s;
    s = {2'b00, a} + {2'b00, b} + {2'b00, c} + {2'b00, d} + (DATA_W+2)'(2);
    return s[DATA_W+1:2];
  endfunction

  // held column: top / bottom sample per channel
  logic [NCH-1:0][DATA_W-1:0] cur_top, cur_bot, pix;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_comb begin
      unique case (kind_i)
        K_EVEN_NEW: pix[c] = mean2(new_top_i[c], new_bot_i[c]);
        K_EVEN_CUR: pix[c] = mean2(cur_top[c], cur_bot[c]);
        K_ODD_NEW:  pix[c] = mean4(cur_top[c], cur_bot[c], new_top_i[c], new_bot_i[c]);
        default:    pix[c] = mean4(cur_top[c], cur_bot[c], cur_top[c], cur_bot[c]);
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_top[c] <= '0;
        cur_bot[c] <= '0;
      end else if (take_i) begin
        cur_top[c] <= new_top_i[c];
        cur_bot[c] <= new_bot_i[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_pix_o   <= '0;
      out_eol_o   <= 1'b0;
      out_eof_o   <= 1'b0;
    end else begin
      out_valid_o <= emit_i;
      out_eol_o   <= emit_i && eol_i;
      out_eof_o   <= emit_i && eof_i;
      if (emit_i) out_pix_o <= pix;
    end
  end

  AST_EOF_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_eof_o) |=> !out_valid_o); // R9

endmodule

// File: rtl/chroma_upsampler420.sv
module chroma_upsampler420
  import chroma_up_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MAX_CW = 1024,
  parameter int MAX_CH = 1024,
  localparam int CW_W   = $clog2(MAX_CW + 1),
  localparam int CH_W   = $clog2(MAX_CH + 1),
  localparam int ADDR_W = $clog2(MAX_CW),
  localparam int NCH    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CW_W-1:0]   cfg_cw_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  output logic              line_req_o,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_cb_i,
  input  logic [DATA_W-1:0] in_cr_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_cb_o,
  output logic [DATA_W-1:0] out_cr_o,
  output logic              out_eol_o,
  output logic              out_eof_o
);

  logic              col_take, emit, top_strm, bot_strm, cache_wr, eol, eof;
  kernel_kind_e      kind;
  logic [ADDR_W-1:0] cache_addr;
  logic [CW_W-1:0]   active_cw;
  logic [NCH-1:0][DATA_W-1:0] strm, cache_rd, new_top, new_bot, out_pix;

  assign strm     = {in_cr_i, in_cb_i};
  assign new_top  = top_strm ? strm : cache_rd;
  assign new_bot  = bot_strm ? strm : new_top;
  assign out_cb_o = out_pix[0];
  assign out_cr_o = out_pix[1];

  chroma_line_seq #(.MAX_CW(MAX_CW), .MAX_CH(MAX_CH)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .cfg_cw_i(cfg_cw_i), .cfg_ch_i(cfg_ch_i), .in_valid_i(in_valid_i),
    .line_req_o(line_req_o), .in_ready_o(in_ready_o), .col_take_o(col_take),
    .emit_o(emit), .emit_kind_o(kind), .top_from_stream_o(top_strm),
    .bot_from_stream_o(bot_strm), .cache_addr_o(cache_addr),
    .cache_wr_o(cache_wr), .eol_o(eol), .eof_o(eof), .active_cw_o(active_cw)
  );

  chroma_line_cache #(.DATA_W(DATA_W), .DEPTH(MAX_CW), .NCH(NCH)) u_cache (
    .clk(clk), .wr_en(cache_wr), .addr(cache_addr),
    .wr_data(strm), .rd_data(cache_rd)
  );

  chroma_kernel #(.DATA_W(DATA_W), .NCH(NCH)) u_kernel (
    .clk(clk), .rst_n(rst_n), .take_i(col_take), .emit_i(emit), .kind_i(kind),
    .eol_i(eol), .eof_i(eof), .new_top_i(new_top), .new_bot_i(new_bot),
    .out_valid_o(out_valid_o), .out_pix_o(out_pix),
    .out_eol_o(out_eol_o), .out_eof_o(out_eof_o)
  );

  // pixels seen so far on the current output line, for the line-length check
  logic [CW_W:0] px_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) px_cnt <= '0;
    else if (out_valid_o) px_cnt <= out_eol_o ? '0 : px_cnt + (CW_W+1)'(1);
  end

  AST_LINE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_eol_o) |-> (px_cnt == ({active_cw, 1'b0} - (CW_W+1)'(1)))); // R9
  AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready_o && !in_valid_i) |=> !out_valid_o); // R10

endmodule

// File: tb/test_chroma_upsampler420.sv
module test_chroma_upsampler420;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int MAX_CW = 1024;
  localparam int MAX_CH = 1024;
  localparam int CW_W = $clog2(MAX_CW + 1);
  localparam int CH_W = $clog2(MAX_CH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [CW_W-1:0] cfg_cw_i = '0;
  logic [CH_W-1:0] cfg_ch_i = '0;
  logic line_req_o, in_valid_i, in_ready_o;
  logic [DATA_W-1:0] in_cb_i, in_cr_i, out_cb_o, out_cr_o;
  logic out_valid_o, out_eol_o, out_eof_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  chroma_upsampler420 #(.DATA_W(DATA_W), .MAX_CW(MAX_CW), .MAX_CH(MAX_CH)) i_chroma_upsampler420 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_cw_i(cfg_cw_i), .cfg_ch_i(cfg_ch_i),
    .line_req_o(line_req_o), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_cb_i(in_cb_i), .in_cr_i(in_cr_i), .out_valid_o(out_valid_o),
    .out_cb_o(out_cb_o), .out_cr_o(out_cr_o), .out_eol_o(out_eol_o), .out_eof_o(out_eof_o)
  );

  typedef struct {
    int cb; int cr; bit eol; bit eof; string tag; int x; int y;
  } exp_t;

  exp_t exp_q[$];
  int pl_cb[];
  int pl_cr[];
  int cur_w = 1, cur_h = 1, gap = 0;
  int checks = 0, fails = 0;
  int acc_cnt = 0, req_cnt = 0, base_acc = 0, base_req = 0;
  bit src_on = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // plane access with the edge repeats folded in
  function automatic int smp(input bit is_cr, input int j, input int i);
    int jj = (j >= cur_h) ? cur_h - 1 : j;
    int ii = (i >= cur_w) ? cur_w - 1 : i;
    return is_cr ? pl_cr[jj*cur_w + ii] : pl_cb[jj*cur_w + ii];
  endfunction

  function automatic int ref_pix(input bit is_cr, input int x, input int y);
    int j = y / 2;
    int i = x / 2;
    int s;
    if (y % 2 == 0) begin
      if (x % 2 == 0) return smp(is_cr, j, i);
      s = smp(is_cr, j, i) + smp(is_cr, j, i + 1);
      return (s + 1) / 2;
    end
    if (x % 2 == 0) begin
      s = smp(is_cr, j, i) + smp(is_cr, j + 1, i);
      return (s + 1) / 2;
    end
    s = smp(is_cr, j, i) + smp(is_cr, j, i + 1) + smp(is_cr, j + 1, i) + smp(is_cr, j + 1, i + 1);
    return (s + 2) / 4;
  endfunction

  // stream-side counters, updated on the edge where the handshake happens
  always @(posedge clk) begin
    if (in_valid_i && in_ready_o) acc_cnt <= acc_cnt + 1;
    if (line_req_o) req_cnt <= req_cnt + 1;
  end

  // source: offers the next plane sample once its line has been requested
  always @(negedge clk) begin
    int idx;
    idx = acc_cnt - base_acc;
    if (line_req_o && src_on)
      check(idx == (req_cnt - base_req) * cur_w, "R2", "request before previous line consumed",
            idx, (req_cnt - base_req) * cur_w);
    if (src_on && idx < (req_cnt - base_req) * cur_w && idx < cur_w * cur_h &&
        $urandom_range(0, gap) == 0) begin
      in_valid_i <= 1'b1;
      in_cb_i <= DATA_W'(pl_cb[idx]);
      in_cr_i <= DATA_W'(pl_cr[idx]);
    end else begin
      in_valid_i <= 1'b0;
      in_cb_i <= '0;
      in_cr_i <= '0;
    end
  end

  // monitor: pops expected pixels as the design produces them
  always @(negedge clk) begin
    exp_t e;
    bit ok;
    if (rst_n && out_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "pixel beyond frame end", 1, 0);
      end else begin
        e = exp_q.pop_front();
        ok = (int'(out_cb_o) == e.cb) && (int'(out_cr_o) == e.cr) &&
             (out_eol_o == e.eol) && (out_eof_o == e.eof);
        if (!ok)
          $display("FAIL %s at x=%0d y=%0d: actual cb=%0d cr=%0d eol=%0b eof=%0b expected cb=%0d cr=%0d eol=%0b eof=%0b",
                   e.tag, e.x, e.y, out_cb_o, out_cr_o, out_eol_o, out_eof_o, e.cb, e.cr, e.eol, e.eof);
        checks++;
        if (!ok) fails++;
      end
    end
  end

  task automatic run_frame(input int w, input int h, input int pat, input int g, input bit poke);
    int t;
    cur_w = w; cur_h = h; gap = g;
    pl_cb = new[w*h];
    pl_cr = new[w*h];
    for (int n = 0; n < w*h; n++) begin
      case (pat)
        0: begin pl_cb[n] = $urandom_range(0, 255); pl_cr[n] = $urandom_range(0, 255); end
        1: begin pl_cb[n] = 255; pl_cr[n] = (n % 2 == 0) ? 255 : 254; end
        default: begin pl_cb[n] = (n * 37) % 256; pl_cr[n] = 255 - (n * 11) % 256; end
      endcase
    end
    for (int y = 0; y < 2*h; y++)
      for (int x = 0; x < 2*w; x++) begin
        exp_t e;
        e.cb = ref_pix(1'b0, x, y);
        e.cr = ref_pix(1'b1, x, y);
        e.eol = (x == 2*w - 1);
        e.eof = (x == 2*w - 1) && (y == 2*h - 1);
        e.x = x; e.y = y;
        if (y % 2 == 1 && y / 2 == h - 1) e.tag = "R8";
        else if (x % 2 == 1 && x / 2 == w - 1) e.tag = "R7";
        else if (y % 2 == 0) e.tag = (x % 2 == 0) ? "R3" : "R4";
        else e.tag = (x % 2 == 0) ? "R5" : "R6";
        exp_q.push_back(e);
      end
    @(negedge clk);
    base_acc = acc_cnt;
    base_req = req_cnt;
    src_on = 1'b1;
    cfg_cw_i = CW_W'(w);
    cfg_ch_i = CH_W'(h);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      // R11: a second start with other sizes while the frame runs
      repeat (20) @(negedge clk);
      cfg_cw_i = CW_W'(3);
      cfg_ch_i = CH_W'(2);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    t = 0;
    while (exp_q.size() != 0 && t < 60000) begin
      @(negedge clk);
      t++;
    end
    check(exp_q.size() == 0, poke ? "R11" : "R9", "pixels missing at frame end", exp_q.size(), 0);
    exp_q.delete();
    repeat (4) @(negedge clk);
    check(req_cnt - base_req == h, "R2", "line requests per frame", req_cnt - base_req, h);
    check(acc_cnt - base_acc == w*h, "R10", "samples accepted per frame", acc_cnt - base_acc, w*h);
    check(!out_valid_o && !in_ready_o && !line_req_o, "R1", "idle after frame",
          {out_valid_o, in_ready_o, line_req_o}, 0);
    src_on = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected frame completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid_o && !in_ready_o && !line_req_o, "R1", "outputs during reset",
          {out_valid_o, in_ready_o, line_req_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid_o && !in_ready_o && !line_req_o, "R1", "outputs after reset",
          {out_valid_o, in_ready_o, line_req_o}, 0);
    run_frame(4, 3, 0, 0, 1'b0);    // R3 R4 R5 R6 basic
    run_frame(1, 1, 0, 0, 1'b0);    // R7 R8 single sample
    run_frame(1, 4, 2, 1, 1'b0);    // R7 one column
    run_frame(5, 1, 0, 2, 1'b0);    // R8 one line
    run_frame(6, 4, 1, 0, 1'b0);    // full-scale rounding
    run_frame(7, 5, 0, 4, 1'b0);    // R10 heavy stalls
    run_frame(6, 4, 2, 1, 1'b1);    // R11 mid-frame start
    run_frame(1024, 2, 0, 0, 1'b0); // R12 widest line
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule